// File: doc/BRIEF.md
# Interrupt Level Priority Selector

This block sits between the interrupt sources of a processor and its trap logic. Every cycle it merges sixteen per-level external request lines with a software-interrupt word into one pending vector. It picks the highest pending level and proposes an external-interrupt trap index for the core to take. The software word carries a timer flag in its lowest bit. That flag is moved up to level 14 before the priority scan, so it competes as a high-priority level rather than as the unselectable level 0.

The core reports the trap index it currently holds. A new level may replace that index only when the core holds nothing, or when it already holds an index of the external-interrupt class. Any other trap class is left alone. When the pending vector empties while the core still holds an external-interrupt index, the block proposes index zero and raises a clear strobe. A separate wake pulse marks every cycle in which at least one external request line rose, so the core can leave its halted state.

Outputs are registered and respond one clock after the inputs are sampled. A synchronous reset clears everything.

Top module: `irq_level_select`

## Requirements
- R1: The pending vector is the OR of three terms: `irq_lines`, `soft_word` with bit 0 masked off, and `soft_word` bit 0 placed at level 14. Bit 0 of `soft_word` never reaches pending level 0.
- R2: Among pending levels 15 down to 1 the highest wins. A vector whose only set bit is level 0 selects nothing: `trap_idx` repeats `core_idx` and both strobes stay low.
- R3: A winning level is loaded only if `core_idx` is zero or `core_idx[8:4]` equals 4 (the external-interrupt class, 0x40).
- R4: A loaded index equals 0x40 OR the winning level, so it lies in 0x41..0x4F with the level in bits [3:0].
- R5: `irq_req` is 1 only when the loaded index differs from `core_idx`. If they are equal, `trap_idx` repeats `core_idx` and `irq_req` is 0.
- R6: With an empty pending vector and `core_idx[8:4]` equal to 4, `trap_idx` becomes 0 and `irq_clr` is 1. With an empty vector and any other `core_idx`, `trap_idx` repeats `core_idx` and `irq_clr` is 0.
- R7: A nonzero `core_idx` outside the external-interrupt class blocks replacement, even when level 15 is pending. `trap_idx` repeats `core_idx` and both strobes stay low.
- R8: `wake` is 1 for one cycle after any `irq_lines` bit goes from 0 to 1. Lowering lines, or holding them steady, leaves `wake` at 0.
- R9: All outputs are registered, so inputs sampled at one clock edge appear after that same edge. A synchronous reset drives `trap_idx`, `irq_req`, `irq_clr` and `wake` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 16 | External request lines, one per level |
| soft_word | input | 16 | Software-interrupt bits; bit 0 is the timer flag |
| core_idx | input | 9 | Trap index currently held by the core |
| trap_idx | output | 9 | Proposed trap index |
| irq_req | output | 1 | Proposed index is a new external interrupt |
| irq_clr | output | 1 | External interrupt withdrawn; index cleared |
| wake | output | 1 | At least one request line rose |

## Verification
The bench uses the default build: sixteen levels, a 9-bit index, class 0x40 and the timer flag mapped to level 14. With these values every concrete index, from the lowest selectable level 0x41 to the top level 0x4F, can be written down directly. The block's edges then fall within a short directed list:
- a level-0-only vector;
- a timer flag that competes with levels 3 and 15;
- current indices just inside the external class (0x41) and just outside it (0x3F, 0x50);
- a core index of zero.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int DEF_LEVELS    = 16;
    localparam int DEF_IDX_W     = 9;
    localparam int DEF_EXT_CLASS = 'h40;
    localparam int DEF_TIMER_BIT = 0;
    localparam int DEF_TIMER_LVL = 14;
endpackage

// File: rtl/irqsel_merge.sv
module irqsel_merge #(
    parameter int NLEVELS   = irqsel_pkg::DEF_LEVELS,
    parameter int TIMER_BIT = irqsel_pkg::DEF_TIMER_BIT,
    parameter int TIMER_LVL = irqsel_pkg::DEF_TIMER_LVL
) (
    input  logic [NLEVELS-1:0] ext_lines,
    input  logic [NLEVELS-1:0] soft_bits,
    output logic [NLEVELS-1:0] pend_vec
);
    localparam logic [NLEVELS-1:0] ONE_HOT = {{(NLEVELS-1){1'b0}}, 1'b1};
    localparam logic [NLEVELS-1:0] TMR_MASK = ONE_HOT << TIMER_BIT;

    logic [NLEVELS-1:0] timer_moved;

    always_comb begin
        timer_moved = '0;
        timer_moved[TIMER_LVL] = soft_bits[TIMER_BIT];
        pend_vec = ext_lines | (soft_bits & ~TMR_MASK) | timer_moved;
    end
endmodule

// File: rtl/irqsel_prio.sv
module irqsel_prio #(
    parameter int NLEVELS = irqsel_pkg::DEF_LEVELS,
    parameter int LVL_W   = $clog2(NLEVELS)
) (
    input  logic [NLEVELS-1:0] vec,
    output logic               found,
    output logic [LVL_W-1:0]   lvl
);
    logic [NLEVELS:0]   above;
    logic [NLEVELS-1:0] pick;
    logic               unused_lvl0;

    assign above[NLEVELS] = 1'b0;
    assign above[0]       = above[1];
    assign pick[0]        = 1'b0;
    assign unused_lvl0    = vec[0];

    for (genvar g = 1; g < NLEVELS; g++) begin : g_scan
        assign above[g] = above[g+1] | vec[g];
        assign pick[g]  = vec[g] & ~above[g+1];
    end

    always_comb begin
        lvl = '0;
        for (int i = 1; i < NLEVELS; i++) begin
            if (pick[i]) lvl = LVL_W'(i);
        end
    end

    assign found = above[1];

    always_comb begin
        if (found) begin
            AST_TOP_WINS: assert ((vec >> lvl) == {{(NLEVELS-1){1'b0}}, 1'b1}); // R2
        end else begin
            AST_NONE_ABOVE_ZERO: assert (vec[NLEVELS-1:1] == '0); // R2
        end
    end
endmodule

// File: rtl/irqsel_rise.sv
module irqsel_rise #(
    parameter int W = irqsel_pkg::DEF_LEVELS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    output logic         rise_q
);
    logic [W-1:0] prev_q;
    logic         rise_d;

    always_comb rise_d = |(lines & ~prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            rise_q <= 1'b0;
        end else begin
            prev_q <= lines;
            rise_q <= rise_d;
        end
    end

    AST_WAKE_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
        rise_q |-> (prev_q != '0)); // R8
endmodule

// File: rtl/irq_level_select.sv
module irq_level_select #(
    parameter int NLEVELS   = irqsel_pkg::DEF_LEVELS,
    parameter int IDX_W     = irqsel_pkg::DEF_IDX_W,
    parameter int EXT_CLASS = irqsel_pkg::DEF_EXT_CLASS,
    parameter int TIMER_BIT = irqsel_pkg::DEF_TIMER_BIT,
    parameter int TIMER_LVL = irqsel_pkg::DEF_TIMER_LVL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NLEVELS-1:0] irq_lines,
    input  logic [NLEVELS-1:0] soft_word,
    input  logic [IDX_W-1:0]   core_idx,
    output logic [IDX_W-1:0]   trap_idx,
    output logic               irq_req,
    output logic               irq_clr,
    output logic               wake
);
    localparam int LVL_W = $clog2(NLEVELS);
    localparam int CLS_W = IDX_W - LVL_W;
    localparam logic [IDX_W-1:0] EXT_VEC = IDX_W'(EXT_CLASS);
    localparam logic [CLS_W-1:0] EXT_CLS = EXT_VEC[IDX_W-1:LVL_W];

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             req;
        logic             clr;
    } sel_t;

    sel_t sel_d, sel_q;

    logic [NLEVELS-1:0] pend_vec;
    logic               win_found;
    logic [LVL_W-1:0]   win_lvl;
    logic               cur_is_ext;
    logic               may_take;
    logic [IDX_W-1:0]   cand_idx;

    irqsel_merge #(
        .NLEVELS  (NLEVELS),
        .TIMER_BIT(TIMER_BIT),
        .TIMER_LVL(TIMER_LVL)
    ) u_merge (
        .ext_lines(irq_lines),
        .soft_bits(soft_word),
        .pend_vec (pend_vec)
    );

    irqsel_prio #(
        .NLEVELS(NLEVELS),
        .LVL_W  (LVL_W)
    ) u_prio (
        .vec  (pend_vec),
        .found(win_found),
        .lvl  (win_lvl)
    );

    irqsel_rise #(
        .W(NLEVELS)
    ) u_rise (
        .clk   (clk),
        .rst   (rst),
        .lines (irq_lines),
        .rise_q(wake)
    );

    always_comb begin
        cur_is_ext = (core_idx[IDX_W-1:LVL_W] == EXT_CLS);
        may_take   = (core_idx == '0) || cur_is_ext;
        cand_idx   = {EXT_CLS, win_lvl};
        sel_d      = '{idx: core_idx, req: 1'b0, clr: 1'b0};
        if (pend_vec != '0) begin
            if (may_take && win_found) begin
                sel_d.idx = cand_idx;
                sel_d.req = (cand_idx != core_idx);
            end
        end else if (cur_is_ext) begin
            sel_d.idx = '0;
            sel_d.clr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_d;
    end

    assign trap_idx = sel_q.idx;
    assign irq_req  = sel_q.req;
    assign irq_clr  = sel_q.clr;

    AST_REQ_IN_CLASS: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (trap_idx[IDX_W-1:LVL_W] == EXT_CLS && trap_idx[LVL_W-1:0] != '0)); // R4
    AST_REQ_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (trap_idx != $past(core_idx))); // R5
    AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_clr |-> (trap_idx == '0 && !irq_req)); // R6
    AST_FOREIGN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (core_idx != '0 && core_idx[IDX_W-1:LVL_W] != EXT_CLS)
        |=> (!irq_req && !irq_clr && trap_idx == $past(core_idx))); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (trap_idx == '0 && !irq_req && !irq_clr && !wake)); // R9
endmodule

// File: tb/tb_irq_level_select.sv
`timescale 1ns/1ps
module tb_irq_level_select;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_lines = '0;
    logic [15:0] soft_word = '0;
    logic [8:0]  core_idx  = '0;
    logic [8:0]  trap_idx;
    logic        irq_req, irq_clr, wake;

    irq_level_select dut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .soft_word(soft_word),
        .core_idx(core_idx), .trap_idx(trap_idx), .irq_req(irq_req),
        .irq_clr(irq_clr), .wake(wake)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [8:0] idx;
        bit         req;
        bit         clr;
        bit         wk;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk  = 0;
    int          n_bad  = 0;
    logic [15:0] prev_e = '0;

    function automatic exp_t model(input logic [15:0] e, input logic [15:0] s,
                                   input logic [8:0] c, input logic [15:0] pe,
                                   input string tag);
        exp_t        r;
        logic [15:0] p;
        bit          hit;
        p = e | (s & 16'hFFFE);
        if (s[0]) p[14] = 1'b1;
        r.idx = c; r.req = 0; r.clr = 0; r.tag = tag;
        r.wk  = |(e & ~pe);
        hit   = 0;
        if (p != 0) begin
            if (c == 0 || c[8:4] == 5'h04) begin
                for (int l = 15; l >= 1; l--) begin
                    if (!hit && p[l]) begin
                        hit   = 1;
                        r.idx = 9'h040 | 9'(l);
                        r.req = (r.idx != c);
                    end
                end
            end
        end else if (c[8:4] == 5'h04) begin
            r.idx = 0;
            r.clr = 1;
        end
        return r;
    endfunction

    task automatic apply(input logic [15:0] e, input logic [15:0] s,
                         input logic [8:0] c, input string tag);
        @(negedge clk);
        irq_lines = e; soft_word = s; core_idx = c;
        sb.push_back(model(e, s, c, prev_e, tag));
        prev_e = e;
    endtask

    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            if (sb.size() != 0) begin
                it = sb.pop_front();
                #5;
                n_chk++;
                if (trap_idx !== it.idx || irq_req !== it.req ||
                    irq_clr !== it.clr || wake !== it.wk) begin
                    n_bad++;
                    $display("FAIL %s: got idx=%h req=%b clr=%b wake=%b, expected idx=%h req=%b clr=%b wake=%b",
                             it.tag, trap_idx, irq_req, irq_clr, wake,
                             it.idx, it.req, it.clr, it.wk);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        core_idx = 9'h045;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (trap_idx !== 0 || irq_req !== 0 || irq_clr !== 0 || wake !== 0) begin
            n_bad++;
            $display("FAIL R9 reset: got idx=%h req=%b clr=%b wake=%b, expected all zero",
                     trap_idx, irq_req, irq_clr, wake);
        end
        rst = 1'b0;

        apply(16'h0000, 16'h0000, 9'h000, "R6 idle, zero index stays");
        apply(16'h0020, 16'h0000, 9'h000, "R4 level 5 loads 0x45, R8 wake");
        apply(16'h0020, 16'h0000, 9'h045, "R5 same index, no strobe");
        apply(16'h0220, 16'h0000, 9'h045, "R2 level 9 beats 5");
        apply(16'h0000, 16'h0001, 9'h000, "R1 timer to level 14");
        apply(16'h0000, 16'h0009, 9'h000, "R1 timer beats soft level 3");
        apply(16'h0000, 16'h0008, 9'h04E, "R1 soft level 3 alone");
        apply(16'h0000, 16'h8001, 9'h000, "R1 soft 15 beats timer");
        apply(16'h0001, 16'h0000, 9'h000, "R2 level 0 only, nothing taken");
        apply(16'h0001, 16'h0000, 9'h045, "R2 level 0 only, ext index held");
        apply(16'h0000, 16'h0000, 9'h04F, "R6 empty clears ext index");
        apply(16'h0000, 16'h0000, 9'h030, "R6 empty, foreign index kept");
        apply(16'h8000, 16'h0000, 9'h020, "R7 foreign 0x20 blocks 15");
        apply(16'h8000, 16'h0000, 9'h050, "R7 foreign 0x50 blocks");
        apply(16'h8000, 16'h0000, 9'h03F, "R7 foreign 0x3F blocks");
        apply(16'h8000, 16'h0000, 9'h041, "R3 ext 0x41 replaced by 15");
        apply(16'h0000, 16'h0000, 9'h04F, "R8 lowering gives no wake");
        apply(16'h0104, 16'h0000, 9'h000, "R8 two lines rise, R4 level 8");
        apply(16'h0104, 16'h0000, 9'h048, "R8 held lines, no wake");
        apply(16'h0004, 16'h0000, 9'h048, "R3 ext index drops to level 2");
        apply(16'h0000, 16'h0000, 9'h000, "R9 settle");
        repeat (3) @(posedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule